// File: doc/BRIEF.md
# Dual-Clock Up/Down Binary Counter

This block is a presettable binary counter (four bits by default) with two count strobes instead of an enable and a direction bit. A rising edge on the up strobe adds one while the down strobe rests high. A rising edge on the down strobe subtracts one while the up strobe rests high. Both strobes are asynchronous to the block. The block samples them on a single system clock through a synchroniser and then detects their rising edges. The count changes on the third system-clock edge after a strobe rises.

An active-high clear forces the count to zero at once, without waiting for a clock edge, and it takes priority over everything else. An active-low load makes the data input appear on the count output at once. The register captures that data on each clock while load is held, so the value stays after load is released. Two active-low terminal outputs copy the waveform of their own strobe while the count sits at its limit, all ones for the up strobe and zero for the down strobe. They can therefore drive the strobes of a next, more significant stage to build a wider counter. If both strobes are low together, or both rise on the same sampled cycle, the count holds and a clash flag pulses for one cycle.

Top module: `dual_clock_counter`

## Requirements
- R1: A rising edge on `upIn` while `downIn` is high increments `count` by one. The new value is visible after the third rising `clk` edge following the change of `upIn`.
- R2: A rising edge on `downIn` while `upIn` is high decrements `count` by one, with the same latency as R1.
- R3: Incrementing from all ones gives zero. Decrementing from zero gives all ones.
- R4: While `masterClr` is high, `count` is zero at once, with no clock edge needed, and `clashErr` is 0. It overrides `loadN`, and any strobe edges that arrive during the clear are lost.
- R5: While `loadN` is low and `masterClr` is low, `count` equals `dataIn` at once, and strobe edges have no effect. After `loadN` returns high, `count` keeps the last loaded value.
- R6: `upTermN` is low exactly when `count` is all ones and `upIn` is low. Otherwise it is high.
- R7: `downTermN` is low exactly when `count` is zero and `downIn` is low. Otherwise it is high.
- R8: When both sampled strobes go low together, or both rise on the same sampled cycle, `count` holds and `clashErr` is high for exactly one cycle.
- R9: Stages chained by connecting `upTermN` to the next stage's `upIn` and `downTermN` to the next stage's `downIn` count as a single wider binary counter, including wraparound at the full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| masterClr | input | 1 | Active-high asynchronous clear |
| loadN | input | 1 | Active-low parallel load |
| upIn | input | 1 | Up-count strobe, rising edge counts; idles high |
| downIn | input | 1 | Down-count strobe, rising edge counts; idles high |
| dataIn | input | WIDTH | Parallel load value |
| count | output | WIDTH | Current count |
| upTermN | output | 1 | Low while count is all ones and upIn is low |
| downTermN | output | 1 | Low while count is zero and downIn is low |
| clashErr | output | 1 | One-cycle pulse on a strobe clash |

## Verification
The bench builds two stages with the default WIDTH of 4 and SYNC_STAGES of 2, chained through the terminal outputs, and compares them against an 8-bit reference. At this width both the carry into the upper nibble and the borrow out of it can be reached. So can a wraparound of the full 8-bit value, in both directions, within a few strobe pulses. Two synchroniser stages make the edge latency short enough that the clash window, the load-masking window and the terminal-output pulse can each be placed exactly on a known clock edge.

// File: rtl/dccnt_pkg.sv
package dccnt_pkg;
  // strobes from edge control to the count datapath
  typedef struct packed {
    logic incr;
    logic decr;
    logic clash;
  } stepCmd_t;
endpackage

// File: rtl/dccnt_sync.sv
module dccnt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstHi,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or posedge rstHi) begin
        if (rstHi) chain <= '1;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or posedge rstHi) begin
        if (rstHi) chain <= '1;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/dccnt_ctrl.sv
module dccnt_ctrl
  import dccnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstHi,
  input  logic     upIn,
  input  logic     downIn,
  output stepCmd_t cmd
);
  logic upSync, downSync;
  logic upPrev, downPrev;
  logic upRise, downRise, bothLow, wasBothLow;

  dccnt_sync #(.STAGES(SYNC_STAGES)) u_syncUp (
    .clk(clk), .rstHi(rstHi), .din(upIn), .dout(upSync)
  );
  dccnt_sync #(.STAGES(SYNC_STAGES)) u_syncDown (
    .clk(clk), .rstHi(rstHi), .din(downIn), .dout(downSync)
  );

  always_ff @(posedge clk or posedge rstHi) begin
    if (rstHi) begin
      upPrev   <= 1'b1;
      downPrev <= 1'b1;
    end else begin
      upPrev   <= upSync;
      downPrev <= downSync;
    end
  end

  always_comb begin
    upRise     = upSync & ~upPrev;
    downRise   = downSync & ~downPrev;
    bothLow    = ~upSync & ~downSync;
    wasBothLow = ~upPrev & ~downPrev;
    cmd.clash  = (upRise & downRise) | (bothLow & ~wasBothLow);
    cmd.incr   = upRise & downSync & ~downRise;
    cmd.decr   = downRise & upSync & ~upRise;
  end
endmodule

// File: rtl/dccnt_dp.sv
module dccnt_dp
  import dccnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstHi,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dataIn,
  input  stepCmd_t         cmd,
  output logic [WIDTH-1:0] count,
  output logic             clashErr
);
  logic [WIDTH-1:0] held;

  always_ff @(posedge clk or posedge rstHi) begin
    if (rstHi) begin
      held     <= '0;
      clashErr <= 1'b0;
    end else if (!loadN) begin
      held     <= dataIn;
      clashErr <= 1'b0;
    end else begin
      clashErr <= cmd.clash;
      if (cmd.incr)      held <= held + WIDTH'(1);
      else if (cmd.decr) held <= held - WIDTH'(1);
    end
  end

  // clear and load reach the output without waiting for a clock
  always_comb begin
    if (rstHi)       count = '0;
    else if (!loadN) count = dataIn;
    else             count = held;
  end
endmodule

// File: rtl/dual_clock_counter.sv
module dual_clock_counter
  import dccnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             masterClr,
  input  logic             loadN,
  input  logic             upIn,
  input  logic             downIn,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             upTermN,
  output logic             downTermN,
  output logic             clashErr
);
  localparam logic [WIDTH-1:0] MAX_COUNT = {WIDTH{1'b1}};

  stepCmd_t stepCmd;

  dccnt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstHi(masterClr), .upIn(upIn), .downIn(downIn), .cmd(stepCmd)
  );

  dccnt_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstHi(masterClr), .loadN(loadN), .dataIn(dataIn),
    .cmd(stepCmd), .count(count), .clashErr(clashErr)
  );

  // terminal outputs copy the raw strobe while the count sits at its limit
  assign upTermN   = ~((count == MAX_COUNT) & ~upIn);
  assign downTermN = ~((count == '0) & ~downIn);
endmodule

// File: rtl/dccnt_checker.sv
module dccnt_checker
  import dccnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             masterClr,
  input logic             loadN,
  input logic [WIDTH-1:0] count,
  input logic             upTermN,
  input logic             downTermN,
  input logic             clashErr,
  input stepCmd_t         cmd
);
  localparam logic [WIDTH-1:0] MAX_COUNT = {WIDTH{1'b1}};

  assert_incr_R1: assert property (@(posedge clk) disable iff (masterClr || !loadN)
    (cmd.incr && !cmd.clash) |=> count == WIDTH'($past(count) + 1'b1));

  assert_decr_R2: assert property (@(posedge clk) disable iff (masterClr || !loadN)
    (cmd.decr && !cmd.clash) |=> count == WIDTH'($past(count) - 1'b1));

  always @(negedge clk) begin
    if (masterClr) begin
      assert_clear_R4: assert (count == '0 && !clashErr);
    end
  end

  assert_upterm_R6: assert property (@(posedge clk) disable iff (masterClr)
    $fell(upTermN) |-> count == MAX_COUNT);

  assert_downterm_R7: assert property (@(posedge clk) disable iff (masterClr)
    $fell(downTermN) |-> count == '0);

  assert_clash_hold_R8: assert property (@(posedge clk) disable iff (masterClr || !loadN)
    clashErr |-> count == $past(count));

  assert_clash_pulse_R8: assert property (@(posedge clk) disable iff (masterClr)
    clashErr |=> !clashErr);
endmodule

bind dual_clock_counter dccnt_checker #(.WIDTH(WIDTH)) u_dccntChecker (
  .clk(clk), .masterClr(masterClr), .loadN(loadN), .count(count),
  .upTermN(upTermN), .downTermN(downTermN), .clashErr(clashErr), .cmd(stepCmd)
);

// File: tb/test_dual_clock_counter.sv
module test_dual_clock_counter;
  localparam int CLK_PERIOD = 10;
  localparam int N_STAGES   = 2;
  localparam int STAGE_W    = 4;
  localparam int TOTAL_W    = N_STAGES * STAGE_W;
  localparam int N_VEC      = 17;

  localparam logic [1:0] OP_RST = 2'd0, OP_LD = 2'd1, OP_UP = 2'd2, OP_DN = 2'd3;

  // {op, data, expected full count}
  localparam logic [17:0] VEC [N_VEC] = '{
    {OP_RST, 8'h00, 8'h00}, {OP_DN, 8'h00, 8'hFF}, {OP_UP, 8'h00, 8'h00},
    {OP_UP,  8'h00, 8'h01}, {OP_LD, 8'h0E, 8'h0E}, {OP_UP, 8'h00, 8'h0F},
    {OP_UP,  8'h00, 8'h10}, {OP_DN, 8'h00, 8'h0F}, {OP_LD, 8'hA7, 8'hA7},
    {OP_DN,  8'h00, 8'hA6}, {OP_LD, 8'h3F, 8'h3F}, {OP_UP, 8'h00, 8'h40},
    {OP_LD,  8'hFE, 8'hFE}, {OP_UP, 8'h00, 8'hFF}, {OP_UP, 8'h00, 8'h00},
    {OP_DN,  8'h00, 8'hFF}, {OP_RST, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic masterClr = 1'b1;
  logic loadN = 1'b1;
  logic upDrive = 1'b1;
  logic downDrive = 1'b1;
  logic [TOTAL_W-1:0] dataAll = '0;
  logic [N_STAGES:0] upChain, downChain;
  logic [N_STAGES-1:0][STAGE_W-1:0] stageCnt;
  logic [N_STAGES-1:0] clashVec;
  logic [TOTAL_W-1:0] fullCount;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign upChain[0]   = upDrive;
  assign downChain[0] = downDrive;
  assign fullCount    = stageCnt;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    dual_clock_counter #(.WIDTH(STAGE_W), .SYNC_STAGES(2)) i_dual_clock_counter (
      .clk(clk), .masterClr(masterClr), .loadN(loadN),
      .upIn(upChain[k]), .downIn(downChain[k]),
      .dataIn(dataAll[k*STAGE_W +: STAGE_W]), .count(stageCnt[k]),
      .upTermN(upChain[k+1]), .downTermN(downChain[k+1]), .clashErr(clashVec[k])
    );
  end

  task automatic check(string req, logic [31:0] actual, logic [31:0] expected);
    nChecks++;
    if (actual !== expected) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic doLoad(logic [TOTAL_W-1:0] v);
    @(negedge clk);
    dataAll = v;
    loadN = 1'b0;
    repeat (2) @(negedge clk);
    loadN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseUp();
    @(negedge clk);
    upDrive = 1'b0;
    repeat (4) @(negedge clk);
    upDrive = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulseDown();
    @(negedge clk);
    downDrive = 1'b0;
    repeat (4) @(negedge clk);
    downDrive = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    masterClr = 1'b1;
    repeat (2) @(negedge clk);
    masterClr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int clashSeen;
    // R4 reset state
    repeat (3) @(negedge clk);
    check("R4 reset count", 32'(fullCount), 32'h00);
    check("R4 reset terminals", 32'({upChain[N_STAGES], downChain[N_STAGES]}), 32'h3);
    check("R4 reset clashErr", 32'(clashVec), 32'h0);
    masterClr = 1'b0;
    repeat (2) @(negedge clk);

    // vector table: R1 R2 R3 R5 R9, terminal outputs idle high (R6 R7)
    for (int i = 0; i < N_VEC; i++) begin
      case (VEC[i][17:16])
        OP_RST: doReset();
        OP_LD:  doLoad(VEC[i][15:8]);
        OP_UP:  pulseUp();
        default: pulseDown();
      endcase
      check($sformatf("R1 R2 R3 R9 vector %0d", i), 32'(fullCount), 32'(VEC[i][7:0]));
      check($sformatf("R6 R7 idle terminals vector %0d", i),
            32'({upChain[N_STAGES], downChain[N_STAGES]}), 32'h3);
    end

    // R5 load appears before any clock edge and masks strobes
    @(negedge clk);
    dataAll = 8'h5A;
    loadN = 1'b0;
    #1;
    check("R5 load immediate", 32'(fullCount), 32'h5A);
    upDrive = 1'b0;
    repeat (3) @(negedge clk);
    upDrive = 1'b1;
    repeat (5) @(negedge clk);
    loadN = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 strobe ignored during load", 32'(fullCount), 32'h5A);

    // R4 clear overrides load, acts without clock
    @(negedge clk);
    dataAll = 8'h33;
    loadN = 1'b0;
    masterClr = 1'b1;
    #1;
    check("R4 clear beats load", 32'(fullCount), 32'h00);
    @(negedge clk);
    loadN = 1'b1;
    masterClr = 1'b0;
    doLoad(8'h77);
    #1;
    masterClr = 1'b1;
    #1;
    check("R4 asynchronous clear", 32'(fullCount), 32'h00);
    @(negedge clk);
    masterClr = 1'b0;

    // R6 terminal up follows strobe only at all ones
    doLoad(8'h0F);
    @(negedge clk);
    upDrive = 1'b0;
    #1;
    check("R6 upTermN low at max", 32'(upChain[1]), 32'h0);
    repeat (3) @(negedge clk);
    check("R6 count holds while strobe low", 32'(fullCount), 32'h0F);
    upDrive = 1'b1;
    #1;
    check("R6 upTermN follows strobe high", 32'(upChain[1]), 32'h1);
    repeat (6) @(negedge clk);
    check("R9 carry into upper stage", 32'(fullCount), 32'h10);
    doLoad(8'h0E);
    @(negedge clk);
    upDrive = 1'b0;
    #1;
    check("R6 upTermN high below max", 32'(upChain[1]), 32'h1);
    upDrive = 1'b1;
    repeat (6) @(negedge clk);

    // R7 terminal down
    doLoad(8'h10);
    @(negedge clk);
    downDrive = 1'b0;
    #1;
    check("R7 downTermN low at zero", 32'(downChain[1]), 32'h0);
    check("R7 upper downTermN high at nonzero", 32'(downChain[2]), 32'h1);
    repeat (3) @(negedge clk);
    downDrive = 1'b1;
    #1;
    check("R7 downTermN follows strobe high", 32'(downChain[1]), 32'h1);
    repeat (6) @(negedge clk);
    check("R9 borrow from upper stage", 32'(fullCount), 32'h0F);

    // R8 clash: both low, then both rise together
    doLoad(8'h55);
    @(negedge clk);
    upDrive = 1'b0;
    downDrive = 1'b0;
    clashSeen = 0;
    repeat (6) begin
      @(negedge clk);
      if (clashVec[0]) clashSeen++;
    end
    check("R8 both low single pulse", 32'(clashSeen), 32'd1);
    upDrive = 1'b1;
    downDrive = 1'b1;
    clashSeen = 0;
    repeat (6) begin
      @(negedge clk);
      if (clashVec[0]) clashSeen++;
    end
    check("R8 both rise single pulse", 32'(clashSeen), 32'd1);
    check("R8 count held on clash", 32'(fullCount), 32'h55);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule